// File: doc/BRIEF.md
# Processor C-State Clock Controller

This block follows the processor through three power states: running (C0), halted (C1) and stop-clock (C2). A halt indication from the processor moves it from C0 to C1. A read strobe on the level-2 register moves it from C0 to C2. In C2 the block drives the active-low stop-clock request that freezes the processor's instruction stream.

While the block is in C1 or C2 it watches a set of break-event inputs and returns to C0 on the first qualified one. The break events are:
- an unmasked interrupt line, with the upper lines counted only in I/O APIC mode;
- an SCI;
- any internal NMI, SMI or INIT event;
- in C2 only, and only when its enable is set, the processor's pending-break indication carried on the floating-point error pin.

A break event that arrives on the same cycle as an entry trigger cancels the entry.

Top module: `cstate_ctrl`

## Requirements
- R1: After reset `cstate_o` is 00 (C0) and `stpclk_no` is 1.
- R2: In C0, when `halt_i` is high, `lvl2_rd_i` is low and no break event is present, `cstate_o` becomes 01 (C1) at the next clock edge, and `stpclk_no` stays 1.
- R3: In C0, when `lvl2_rd_i` is high and no C2 break event is present, `cstate_o` becomes 10 (C2) at the next edge. This holds even when `halt_i` is also high, because the level-2 read wins.
- R4: An entry trigger is cancelled when a break event arrives in the same cycle, and the state stays 00. A halt is cancelled by the common break events (R5 to R7). A level-2 read is additionally cancelled by a pending break that is enabled.
- R5: In C1 or C2, an interrupt line with `irq_i[n]=1` and `irq_mask_i[n]=0` returns the state to 00 at the next edge. A line whose mask bit is 1 has no effect.
- R6: Lines at index LEGACY_IRQ and above qualify only when `apic_mode_i=1`. With `apic_mode_i=0` they are ignored.
- R7: `sci_i`, `nmi_evt_i`, `smi_evt_i` and `init_evt_i` are each a break event in both C1 and C2.
- R8: `pend_brk_i` ends C2 only when `ferr_brk_en_i=1`. It never ends C1.
- R9: `stpclk_no` is 0 exactly while `cstate_o` is 10. It returns to 1 at the edge after a qualified break in C2.
- R10: `cstate_o` never takes the value 11.
- R11: In C1 or C2, entry triggers with no break event have no effect. A halt in C2 stays in C2, and a level-2 read in C1 stays in C1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Processor halt indication |
| lvl2_rd_i | input | 1 | Level-2 register read strobe |
| irq_i | input | NUM_IRQ | Interrupt request lines |
| irq_mask_i | input | NUM_IRQ | Interrupt masks, 1 = masked |
| apic_mode_i | input | 1 | 1 = all lines qualify, 0 = only lines below LEGACY_IRQ |
| sci_i | input | 1 | SCI active |
| nmi_evt_i | input | 1 | Internal NMI event |
| smi_evt_i | input | 1 | Internal SMI event |
| init_evt_i | input | 1 | Internal INIT event |
| pend_brk_i | input | 1 | Processor pending-break indication |
| ferr_brk_en_i | input | 1 | Enables the pending break as a C2 break event |
| stpclk_no | output | 1 | Stop-clock request, active low |
| cstate_o | output | 2 | Current state: 00 C0, 01 C1, 10 C2 |

## Verification
The bench builds the block with NUM_IRQ=24 and LEGACY_IRQ=16. These are the defaults, so it covers both the 16-line legacy range and the eight extra APIC lines. With these values, line 20 can be shown to be ignored with `apic_mode_i=0` and to end C2 with `apic_mode_i=1`. Lines 3 and 15 exercise the masked and unmasked cases at the low end. The pending break is driven in C1 and in C2 with its enable at both values.

// File: rtl/cstate_pkg.sv
package cstate_pkg;
  typedef enum logic [1:0] {
    CS_C0 = 2'b00,
    CS_C1 = 2'b01,
    CS_C2 = 2'b10
  } cstate_e;
endpackage

// File: rtl/cstate_brk_qual.sv
module cstate_brk_qual #(
  parameter int NUM_IRQ    = 24,
  parameter int LEGACY_IRQ = 16
) (
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] irq_mask_i,
  input  logic               apic_mode_i,
  input  logic               sci_i,
  input  logic               nmi_evt_i,
  input  logic               smi_evt_i,
  input  logic               init_evt_i,
  input  logic               pend_brk_i,
  input  logic               ferr_brk_en_i,
  output logic               brk_c1_o,
  output logic               brk_c2_o
);
  logic [NUM_IRQ-1:0] line_ok;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    if (g < LEGACY_IRQ) begin : g_legacy
      assign line_ok[g] = irq_i[g] & ~irq_mask_i[g];
    end else begin : g_apic
      assign line_ok[g] = irq_i[g] & ~irq_mask_i[g] & apic_mode_i;
    end
  end

  // common break set, valid in C1 and C2
  assign brk_c1_o = (|line_ok) | sci_i | nmi_evt_i | smi_evt_i | init_evt_i;
  // pending break only counts toward C2
  assign brk_c2_o = brk_c1_o | (pend_brk_i & ferr_brk_en_i);
endmodule

// File: rtl/cstate_fsm.sv
module cstate_fsm
  import cstate_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    halt_i,
  input  logic    lvl2_rd_i,
  input  logic    brk_c1_i,
  input  logic    brk_c2_i,
  output cstate_e state_o,
  output logic    stpclk_no
);
  cstate_e state_q, state_d;
  logic    stp_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CS_C0: begin
        if (lvl2_rd_i)   state_d = brk_c2_i ? CS_C0 : CS_C2;
        else if (halt_i) state_d = brk_c1_i ? CS_C0 : CS_C1;
      end
      CS_C1:   if (brk_c1_i) state_d = CS_C0;
      CS_C2:   if (brk_c2_i) state_d = CS_C0;
      default: state_d = CS_C0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CS_C0;
      stp_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      stp_q   <= (state_d != CS_C2);
    end
  end

  assign state_o   = state_q;
  assign stpclk_no = stp_q;
endmodule

// File: rtl/cstate_ctrl.sv
module cstate_ctrl
  import cstate_pkg::*;
#(
  parameter int NUM_IRQ    = 24,
  parameter int LEGACY_IRQ = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               halt_i,
  input  logic               lvl2_rd_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] irq_mask_i,
  input  logic               apic_mode_i,
  input  logic               sci_i,
  input  logic               nmi_evt_i,
  input  logic               smi_evt_i,
  input  logic               init_evt_i,
  input  logic               pend_brk_i,
  input  logic               ferr_brk_en_i,
  output logic               stpclk_no,
  output logic [1:0]         cstate_o
);
  logic    brk_c1, brk_c2;
  cstate_e state;

  cstate_brk_qual #(.NUM_IRQ(NUM_IRQ), .LEGACY_IRQ(LEGACY_IRQ)) u_qual (
    .irq_i         (irq_i),
    .irq_mask_i    (irq_mask_i),
    .apic_mode_i   (apic_mode_i),
    .sci_i         (sci_i),
    .nmi_evt_i     (nmi_evt_i),
    .smi_evt_i     (smi_evt_i),
    .init_evt_i    (init_evt_i),
    .pend_brk_i    (pend_brk_i),
    .ferr_brk_en_i (ferr_brk_en_i),
    .brk_c1_o      (brk_c1),
    .brk_c2_o      (brk_c2)
  );

  cstate_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .halt_i    (halt_i),
    .lvl2_rd_i (lvl2_rd_i),
    .brk_c1_i  (brk_c1),
    .brk_c2_i  (brk_c2),
    .state_o   (state),
    .stpclk_no (stpclk_no)
  );

  assign cstate_o = state;
endmodule

// File: rtl/cstate_ctrl_chk.sv
module cstate_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       halt_i,
  input logic       lvl2_rd_i,
  input logic       pend_brk_i,
  input logic       ferr_brk_en_i,
  input logic       brk_c1,
  input logic       brk_c2,
  input logic       stpclk_no,
  input logic [1:0] cstate_o
);
  // R2
  halt_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cstate_o == 2'b00 && halt_i && !lvl2_rd_i && !brk_c1) |=> (cstate_o == 2'b01));
  // R3
  lvl2_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cstate_o == 2'b00 && lvl2_rd_i && !brk_c2) |=> (cstate_o == 2'b10));
  // R4
  entry_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cstate_o == 2'b00 && brk_c1) |=> (cstate_o == 2'b00));
  // R5
  break_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cstate_o != 2'b00 && brk_c1) |=> (cstate_o == 2'b00));
  // R8
  pend_exit_c2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cstate_o == 2'b10 && pend_brk_i && ferr_brk_en_i) |=> (cstate_o == 2'b00));
  // R8
  pend_hold_c1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cstate_o == 2'b01 && !brk_c1) |=> (cstate_o == 2'b01));
  // R9
  stp_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stpclk_no) == (cstate_o == 2'b10));
  // R9
  stp_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stpclk_no) |-> $past(lvl2_rd_i));
  // R10
  state_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cstate_o));
endmodule

bind cstate_ctrl cstate_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .halt_i        (halt_i),
  .lvl2_rd_i     (lvl2_rd_i),
  .pend_brk_i    (pend_brk_i),
  .ferr_brk_en_i (ferr_brk_en_i),
  .brk_c1        (brk_c1),
  .brk_c2        (brk_c2),
  .stpclk_no     (stpclk_no),
  .cstate_o      (cstate_o)
);

// File: tb/cstate_ctrl_tb.sv
`timescale 1ns/1ps
module cstate_ctrl_tb;
  localparam int NIRQ = 24;
  localparam int LEG  = 16;

  typedef struct {
    logic [1:0] st;
    logic       stp;
    string      tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            halt, lvl2, apic, sci, nmi, smi, init_e, pend, ferr;
  logic [NIRQ-1:0] irq, mask;
  logic            stp_n;
  logic [1:0]      cst;

  int   checks = 0;
  int   errors = 0;
  exp_t exp_q[$];
  logic [1:0] model_st = 2'b00;

  always #2.5 clk = ~clk;

  cstate_ctrl #(.NUM_IRQ(NIRQ), .LEGACY_IRQ(LEG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .halt_i(halt), .lvl2_rd_i(lvl2),
    .irq_i(irq), .irq_mask_i(mask), .apic_mode_i(apic), .sci_i(sci),
    .nmi_evt_i(nmi), .smi_evt_i(smi), .init_evt_i(init_e),
    .pend_brk_i(pend), .ferr_brk_en_i(ferr),
    .stpclk_no(stp_n), .cstate_o(cst)
  );

  task automatic clr();
    halt = 0; lvl2 = 0; apic = 0; sci = 0; nmi = 0; smi = 0; init_e = 0;
    pend = 0; ferr = 0; irq = '0; mask = '0;
  endtask

  // driver: compute the expected result of the coming edge, push it, wait a cycle
  task automatic step(input string tag);
    logic iq, b1, b2;
    logic [1:0] nx;
    exp_t e;
    iq = 1'b0;
    for (int i = 0; i < NIRQ; i++)
      if (irq[i] && !mask[i] && (i < LEG || apic)) iq = 1'b1;
    b1 = iq | sci | nmi | smi | init_e;
    b2 = b1 | (pend & ferr);
    nx = model_st;
    case (model_st)
      2'b00: if (lvl2) nx = b2 ? 2'b00 : 2'b10;
             else if (halt) nx = b1 ? 2'b00 : 2'b01;
      2'b01: if (b1) nx = 2'b00;
      2'b10: if (b2) nx = 2'b00;
      default: nx = 2'b00;
    endcase
    model_st = nx;
    e.st = nx; e.stp = (nx != 2'b10); e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    clr();
  endtask

  // monitor
  initial forever begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (cst !== e.st || stp_n !== e.stp) begin
        errors++;
        $display("FAIL %s: state=%b stpclk_n=%b expected state=%b stpclk_n=%b",
                 e.tag, cst, stp_n, e.st, e.stp);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    checks++;
    if (cst !== 2'b00 || stp_n !== 1'b1) begin
      errors++;
      $display("FAIL R1: state=%b stpclk_n=%b expected state=00 stpclk_n=1", cst, stp_n);
    end
    rst_n = 1'b1;
    @(negedge clk);
    step("R1 idle");
    halt = 1; step("R2 halt enters C1");
    irq[3] = 1; mask[3] = 1; step("R5 masked line ignored in C1");
    pend = 1; ferr = 1; step("R8 pending break ignored in C1");
    lvl2 = 1; step("R11 level-2 read ignored in C1");
    irq[3] = 1; step("R5 unmasked line ends C1");
    lvl2 = 1; step("R3 level-2 read enters C2");
    halt = 1; step("R11 halt ignored in C2");
    pend = 1; ferr = 0; step("R8 pending break without enable in C2");
    pend = 1; ferr = 1; step("R8 pending break with enable ends C2");
    lvl2 = 1; irq[20] = 1; apic = 0; step("R6 upper line ignored, entry proceeds");
    irq[20] = 1; apic = 0; step("R6 upper line ignored in C2");
    irq[20] = 1; apic = 1; step("R6 upper line ends C2 in APIC mode");
    halt = 1; sci = 1; step("R4 SCI cancels halt entry");
    lvl2 = 1; nmi = 1; step("R4 NMI cancels C2 entry");
    lvl2 = 1; pend = 1; ferr = 1; step("R4 enabled pending break cancels C2 entry");
    halt = 1; lvl2 = 1; step("R3 level-2 read wins over halt");
    smi = 1; step("R7 SMI ends C2, R9 stop-clock released");
    halt = 1; step("R2 halt enters C1 again");
    init_e = 1; step("R7 INIT ends C1");
    lvl2 = 1; step("R3 enter C2 again");
    sci = 1; step("R7 SCI ends C2");
    halt = 1; step("R2 enter C1");
    nmi = 1; step("R7 NMI ends C1");
    lvl2 = 1; step("R9 enter C2");
    irq[15] = 1; step("R5 top legacy line ends C2");
    step("R10 idle");
    @(posedge clk);
    #2;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule